// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block sends one SD/MMC command to a card-side agent and stores the reply. Software first loads a 32-bit argument and then a command word. When the command word has its start bit set, the block offers the command index and argument on a request port. The card agent accepts the request, returns zero or more response bytes, and then signals the end of the reply.

The block judges the reply against what the command word asked for. A valid reply is packed into four 32-bit response words, most significant byte first. A reply that is missing, has the wrong length, or is flagged as a card error raises a timeout status. Commands that expect no reply only raise a sent status.

The command word bits are: index in bits 5:0, response expected in bit 6, long response in bit 7, interrupt mode in bit 8 (stored only), pending in bit 9, start in bit 10. After reset the block is idle. Software reads the outcome from three sticky status outputs. A new start clears them.

Top module: `sdc_cmd_engine`

## Requirements
- R1: While reset is applied, and after it is released, every output is zero and `busy` is low.
- R2: A write with `wr_sel`=0 stores `wr_data` as the argument. A write with `wr_sel`=1 stores `wr_data[10:0]` as the command word. Writes arriving while `busy` is high change neither register.
- R3: A command write with bit 10 set and bit 9 clear makes `busy` high and clears all three status bits. From the next cycle it raises `req_valid`, with `req_index` equal to command bits 5:0 and `req_arg` equal to the argument. `req_valid` stays high until a cycle in which `req_ready` is high.
- R4: A command write with both bit 10 and bit 9 set issues no request and leaves the status bits unchanged. The stored command word shows bit 10 cleared.
- R5: When `rsp_done` arrives after the request is accepted, the command finishes in that cycle's edge. `busy` falls and bit 10 of the stored command word clears, whatever the outcome.
- R6: With command bit 6 clear and `rsp_err` low at `rsp_done`, `st_sent` is set and the response words keep their values.
- R7: `st_timeout` is set, and the response words keep their values, in any of these cases: `rsp_err` is high at `rsp_done`; or bit 6 is set and the byte count is 0; or bit 6 is set and the count is 4 while bit 7 is set; or bit 6 is set and the count is neither 4 nor 16.
- R8: A valid 4-byte reply sets `st_resp_end`. It writes `resp0` with the first byte in bits 31:24 through the fourth byte in bits 7:0, and writes zero to `resp1` to `resp3`.
- R9: A valid 16-byte reply sets `st_resp_end`. It fills `resp0` to `resp3` in order, four bytes each, first byte of each word in bits 31:24, with bit 0 of `resp3` forced to zero.
- R10: A byte presented in the same cycle as `rsp_done` counts toward the reply. Bytes presented while no command is waiting for its reply are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | 0 selects argument, 1 selects command word |
| wr_data | input | 32 | Write data |
| arg_q | output | 32 | Stored argument |
| cmd_q | output | 11 | Stored command word |
| req_valid | output | 1 | Command offered to card agent |
| req_ready | input | 1 | Card agent accepts the command |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_byte_valid | input | 1 | Response byte present |
| rsp_byte | input | 8 | Response byte |
| rsp_done | input | 1 | End of reply |
| rsp_err | input | 1 | Card error, sampled with rsp_done |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| st_sent | output | 1 | Command sent without reply |
| st_resp_end | output | 1 | Valid reply captured |
| st_timeout | output | 1 | Reply missing, malformed or in error |
| busy | output | 1 | Command in progress |

## Verification
The final response byte and the end-of-reply strobe can arrive in the same cycle. The judgement must then count that byte, so a 4-byte reply whose fourth byte coincides with `rsp_done` has to pass rather than time out. The bench delivers replies both merged that way and with `rsp_done` in a separate cycle. A behavioural queue model counts bytes the same way and is compared with every output on each clock. A software write landing while a command is outstanding is also provoked, and judged by the argument and command word staying unchanged.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_W   = 11;
  localparam int CB_RESP = 6;
  localparam int CB_LONG = 7;
  localparam int CB_PEND = 9;
  localparam int CB_EN   = 10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_t;
  typedef enum logic [1:0] {V_SENT, V_RESP, V_TMO} verdict_t;
endpackage

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
  import sdc_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_done,
  output seq_t state,
  output logic req_valid,
  output logic finish
);
  seq_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      SQ_IDLE: if (start) state_d = SQ_REQ;
      SQ_REQ:  if (req_ready) state_d = SQ_WAIT;
      SQ_WAIT: if (rsp_done) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state <= SQ_IDLE;
    else         state <= state_d;
  end

  assign req_valid = (state == SQ_REQ);
  assign finish    = (state == SQ_WAIT) && rsp_done;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !req_ready) |=> req_valid);
  p_finish_idle_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    finish |=> (state == SQ_IDLE));
endmodule

// File: rtl/sdc_rsp_shift.sv
module sdc_rsp_shift #(
  parameter int BYTES  = 16,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTES + 2)
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    clr,
  input  logic                    take,
  input  logic [BYTE_W-1:0]       byte_in,
  output logic [BYTES*BYTE_W-1:0] buf_d,
  output logic [CNT_W-1:0]        cnt_d
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTES);

  logic [BYTES*BYTE_W-1:0] buf_q;
  logic [CNT_W-1:0]        cnt_q;

  always_comb begin
    buf_d = buf_q;
    cnt_d = cnt_q;
    if (clr) begin
      buf_d = '0;
      cnt_d = '0;
    end else if (take) begin
      if (cnt_q < CNT_FULL) buf_d = {buf_q[BYTES*BYTE_W-BYTE_W-1:0], byte_in};
      if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (clr || take) begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_TOP);
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/sdc_rsp_judge.sv
module sdc_rsp_judge
  import sdc_pkg::*;
#(
  parameter int BYTES  = 16,
  parameter int SHORT  = 4,
  parameter int WORD_W = 32,
  localparam int NW    = BYTES * 8 / WORD_W,
  localparam int CNT_W = $clog2(BYTES + 2)
) (
  input  logic                   want_resp,
  input  logic                   want_long,
  input  logic                   err,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [BYTES*8-1:0]     bytes_in,
  output verdict_t               verdict,
  output logic [NW-1:0][WORD_W-1:0] words
);
  logic is_short;
  logic bad_len;

  assign is_short = (cnt == CNT_W'(SHORT));
  assign bad_len  = (cnt == '0) || (is_short && want_long) ||
                    (!is_short && (cnt != CNT_W'(BYTES)));

  always_comb begin
    if (err)             verdict = V_TMO;
    else if (!want_resp) verdict = V_SENT;
    else if (bad_len)    verdict = V_TMO;
    else                 verdict = V_RESP;
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    localparam logic [WORD_W-1:0] KEEP =
      (k == NW - 1) ? ~{{(WORD_W-1){1'b0}}, 1'b1} : {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0] SHORT_SEL = (k == 0) ? {WORD_W{1'b1}} : '0;
    assign words[k] = is_short ? (bytes_in[WORD_W-1:0] & SHORT_SEL)
                               : (bytes_in[(NW-1-k)*WORD_W +: WORD_W] & KEEP);
  end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int ARG_W     = 32,
  parameter int LONG_LEN  = 16,
  parameter int SHORT_LEN = 4,
  localparam int WORD_W   = 32,
  localparam int NW       = LONG_LEN * 8 / WORD_W,
  localparam int CNT_W    = $clog2(LONG_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  output logic [ARG_W-1:0] arg_q,
  output logic [CMD_W-1:0] cmd_q,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [5:0]       req_index,
  output logic [ARG_W-1:0] req_arg,
  input  logic             rsp_byte_valid,
  input  logic [7:0]       rsp_byte,
  input  logic             rsp_done,
  input  logic             rsp_err,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3,
  output logic             st_sent,
  output logic             st_resp_end,
  output logic             st_timeout,
  output logic             busy
);
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  seq_t     state;
  logic     finish, idle, wr_arg, wr_cmd, start;
  verdict_t verdict;
  logic [LONG_LEN*8-1:0] buf_d;
  logic [CNT_W-1:0]      cnt_d;
  logic [NW-1:0][WORD_W-1:0] words, resp_q, resp_d;
  logic [ARG_W-1:0] arg_d;
  logic [CMD_W-1:0] cmd_d;
  logic [2:0] stat_q, stat_d;

  assign idle   = (state == SQ_IDLE);
  assign wr_arg = wr_en && idle && !wr_sel;
  assign wr_cmd = wr_en && idle && wr_sel;
  assign start  = wr_cmd && wr_data[CB_EN] && !wr_data[CB_PEND];

  sdc_cmd_seq u_seq (
    .clk(clk), .rst_ni(rst_i), .start(start), .req_ready(req_ready),
    .rsp_done(rsp_done), .state(state), .req_valid(req_valid), .finish(finish)
  );

  sdc_rsp_shift #(.BYTES(LONG_LEN), .BYTE_W(8)) u_shift (
    .clk(clk), .rst_ni(rst_i), .clr(start),
    .take(rsp_byte_valid && (state == SQ_WAIT)),
    .byte_in(rsp_byte), .buf_d(buf_d), .cnt_d(cnt_d)
  );

  sdc_rsp_judge #(.BYTES(LONG_LEN), .SHORT(SHORT_LEN), .WORD_W(WORD_W)) u_judge (
    .want_resp(cmd_q[CB_RESP]), .want_long(cmd_q[CB_LONG]), .err(rsp_err),
    .cnt(cnt_d), .bytes_in(buf_d), .verdict(verdict), .words(words)
  );

  always_comb begin
    arg_d  = wr_arg ? wr_data[ARG_W-1:0] : arg_q;
    cmd_d  = cmd_q;
    stat_d = stat_q;
    resp_d = resp_q;
    if (wr_cmd) begin
      cmd_d = wr_data[CMD_W-1:0];
      if (wr_data[CB_PEND]) cmd_d[CB_EN] = 1'b0;
      if (start) stat_d = '0;
    end else if (finish) begin
      cmd_d[CB_EN] = 1'b0;
      case (verdict)
        V_SENT:  stat_d[0] = 1'b1;
        V_RESP:  begin stat_d[1] = 1'b1; resp_d = words; end
        default: stat_d[2] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      arg_q  <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
      resp_q <= '0;
    end else begin
      if (wr_arg)           arg_q  <= arg_d;
      if (wr_cmd || finish) begin
        cmd_q  <= cmd_d;
        stat_q <= stat_d;
        resp_q <= resp_d;
      end
    end
  end

  assign req_index   = cmd_q[5:0];
  assign req_arg     = arg_q;
  assign resp0       = resp_q[0];
  assign resp1       = resp_q[1];
  assign resp2       = resp_q[2];
  assign resp3       = resp_q[3];
  assign st_sent     = stat_q[0];
  assign st_resp_end = stat_q[1];
  assign st_timeout  = stat_q[2];
  assign busy        = !idle;

  p_en_idle_r5: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |-> !cmd_q[CB_EN]);
  p_one_status_r7: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({st_sent, st_resp_end, st_timeout}));
  p_long_lsb_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (st_resp_end && cmd_q[CB_LONG]) |-> !resp3[0]);
  p_busy_arg_r2: assert property (@(posedge clk) disable iff (!rst_i)
    busy |=> $stable(arg_q));
  p_pend_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && wr_sel && !busy && wr_data[CB_EN] && wr_data[CB_PEND]) |=> !busy);
endmodule

// File: tb/sdc_cmd_engine_tb.sv
module sdc_cmd_engine_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_sel, req_ready, rsp_byte_valid, rsp_done, rsp_err;
  logic [31:0] wr_data;
  logic [7:0]  rsp_byte;
  logic [31:0] arg_q, req_arg, resp0, resp1, resp2, resp3;
  logic [10:0] cmd_q;
  logic [5:0]  req_index;
  logic req_valid, st_sent, st_resp_end, st_timeout, busy;

  always #2 clk = ~clk;

  sdc_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .arg_q(arg_q), .cmd_q(cmd_q), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_arg(req_arg), .rsp_byte_valid(rsp_byte_valid),
    .rsp_byte(rsp_byte), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .st_sent(st_sent), .st_resp_end(st_resp_end), .st_timeout(st_timeout), .busy(busy)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state = 0;
  logic [31:0] m_arg = 0;
  logic [10:0] m_cmd = 0;
  logic [31:0] m_resp [4] = '{0, 0, 0, 0};
  bit m_sent = 0, m_re = 0, m_to = 0;
  logic [7:0] q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_arg = 0; m_cmd = 0; m_sent = 0; m_re = 0; m_to = 0;
      foreach (m_resp[k]) m_resp[k] = 0;
      q.delete();
    end else if (m_state == 0) begin
      if (wr_en && !wr_sel) m_arg = wr_data;
      if (wr_en && wr_sel) begin
        m_cmd = wr_data[10:0];
        if (wr_data[10] && wr_data[9]) m_cmd[10] = 1'b0;
        else if (wr_data[10]) begin
          m_state = 1; m_sent = 0; m_re = 0; m_to = 0;
        end
      end
    end else if (m_state == 1) begin
      if (req_ready) begin m_state = 2; q.delete(); end
    end else begin
      if (rsp_byte_valid) q.push_back(rsp_byte);
      if (rsp_done) begin
        int n;
        n = q.size();
        if (rsp_err) m_to = 1;
        else if (!m_cmd[6]) m_sent = 1;
        else if (n == 0 || (n == 4 && m_cmd[7]) || (n != 4 && n != 16)) m_to = 1;
        else begin
          m_re = 1;
          for (int k = 0; k < 4; k++) begin
            if (n == 4) m_resp[k] = (k == 0) ? {q[0], q[1], q[2], q[3]} : 32'h0;
            else m_resp[k] = {q[4*k], q[4*k+1], q[4*k+2], q[4*k+3]};
          end
          if (n == 16) m_resp[3][0] = 1'b0;
        end
        m_cmd[10] = 1'b0;
        m_state = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R5 busy", busy, m_state != 0);
      chk("R2 arg_q", arg_q, m_arg);
      chk("R5 cmd_q", cmd_q, m_cmd);
      chk("R3 req_valid", req_valid, m_state == 1);
      if (m_state == 1) chk("R3 req fields", {req_index, req_arg}, {m_cmd[5:0], m_arg});
      chk("R6/R7/R8 status", {st_sent, st_resp_end, st_timeout}, {m_sent, m_re, m_to});
      chk("R8/R9 resp", {resp0, resp1, resp2, resp3},
          {m_resp[0], m_resp[1], m_resp[2], m_resp[3]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [7:0] bval(input logic [7:0] b0, input int i);
    return b0 + 8'(i * 17);
  endfunction

  task automatic card(input int n, input bit err, input bit merge, input logic [7:0] b0);
    while (!req_valid) @(negedge clk);
    @(negedge clk);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    for (int i = 0; i < n; i++) begin
      rsp_byte_valid = 1; rsp_byte = bval(b0, i);
      if (merge && i == n - 1) begin rsp_done = 1; rsp_err = err; end
      @(negedge clk);
    end
    if (!merge || n == 0) begin
      rsp_byte_valid = 0; rsp_done = 1; rsp_err = err;
      @(negedge clk);
    end
    rsp_byte_valid = 0; rsp_done = 0; rsp_err = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; req_ready = 0;
    rsp_byte_valid = 0; rsp_byte = 0; rsp_done = 0; rsp_err = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {arg_q, cmd_q, req_valid, busy, st_sent, st_resp_end, st_timeout, resp0},
        '0);
    cmp_on = 1;
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {busy, req_valid, resp3}, '0);

    // R2: plain writes
    wr(0, 32'hCAFE_0001);
    wr(1, 32'h0000_0055);
    chk("R2 arg write", arg_q, 32'hCAFE_0001);
    chk("R2 cmd write", cmd_q, 11'h055);

    // R6: no reply expected
    wr(1, 32'h402);
    chk("R3 busy on start", busy, 1'b1);
    card(0, 0, 0, 8'h00);
    chk("R6 sent", {st_sent, st_resp_end, st_timeout}, 3'b100);

    // R8 + R10: 4 bytes, last merged with done
    wr(0, 32'h1234_5678);
    wr(1, 32'h451);
    card(4, 0, 1, 8'h11);
    chk("R8 resp0", resp0, 32'h1122_3344);
    chk("R8 resp1..3", {resp1, resp2, resp3}, '0);
    chk("R10 merged last byte", st_resp_end, 1'b1);

    // R2: write during busy ignored; R9 long reply
    wr(1, 32'h4C0);
    wr(0, 32'hDEAD_BEEF);
    wr(1, 32'h000);
    chk("R2 arg held while busy", arg_q, 32'h1234_5678);
    chk("R2 cmd held while busy", cmd_q, 11'h4C0);
    card(16, 0, 0, 8'h10);
    chk("R9 resp0", resp0, {bval(8'h10,0), bval(8'h10,1), bval(8'h10,2), bval(8'h10,3)});
    chk("R9 resp3 lsb", resp3, {bval(8'h10,12), bval(8'h10,13), bval(8'h10,14), bval(8'h10,15) & 8'hFE});
    chk("R5 enable cleared", cmd_q[10], 1'b0);

    // R7: long requested, 4 bytes
    wr(1, 32'h4C3);
    card(4, 0, 0, 8'h21);
    chk("R7 long vs 4", st_timeout, 1'b1);
    chk("R7 resp kept", resp0, {bval(8'h10,0), bval(8'h10,1), bval(8'h10,2), bval(8'h10,3)});
    // R7: zero bytes
    wr(1, 32'h441);
    card(0, 0, 0, 8'h00);
    chk("R7 zero length", st_timeout, 1'b1);
    // R7: five bytes
    wr(1, 32'h442);
    card(5, 0, 1, 8'h30);
    chk("R7 odd length", st_timeout, 1'b1);
    // R7: seventeen bytes on long
    wr(1, 32'h4C4);
    card(17, 0, 0, 8'h40);
    chk("R7 overlong", st_timeout, 1'b1);
    // R7: card error with no reply expected
    wr(1, 32'h405);
    card(0, 1, 0, 8'h00);
    chk("R7 card error", {st_sent, st_timeout}, 2'b01);

    // R4: pending command not started
    wr(1, 32'h646);
    repeat (3) @(negedge clk);
    chk("R4 no request", {busy, req_valid}, 2'b00);
    chk("R4 enable dropped", cmd_q, 11'h246);
    chk("R4 status kept", st_timeout, 1'b1);

    // R10: stray bytes while idle ignored
    rsp_byte_valid = 1; rsp_byte = 8'hEE;
    repeat (3) @(negedge clk);
    rsp_byte_valid = 0;
    wr(1, 32'h447);
    card(4, 0, 0, 8'h05);
    chk("R10 stray bytes ignored", resp0, {bval(8'h05,0), bval(8'h05,1), bval(8'h05,2), bval(8'h05,3)});

    // R8: 16 bytes without long bit is still accepted
    wr(1, 32'h448);
    card(16, 0, 1, 8'h01);
    chk("R8/R9 16 bytes short cmd", st_resp_end, 1'b1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule